// File: doc/BRIEF.md
# Three-and-a-half-digit common-anode segment driver

This block turns a latched decimal reading into drive patterns for a row of common-anode LED digits. The reading has three full digits, a leading half digit that can only show 1 or nothing, a polarity flag and an overrange flag. The block decodes each digit into its seven segments. It lights a minus segment for negative readings. On overrange it shows a lone leading "1" and darkens the rest of the row.

An internal divider makes a square wave for the shared anode line. Every segment pin is driven as a square wave against that line. A lit segment sits in the opposite phase to the common line, and a dark segment sits in the same phase. The common line and all segment pins come from registers that load on the same clock edge, so they never skew against each other. There is no decimal point output.

Top module: `disp35_ca_drv`

## Requirements
- R1: While reset is asserted, and on the first edge after it, the common line and every segment output are low.
- R2: The common line toggles once every DIV_HALF clock cycles. The first toggle comes on the DIV_HALF-th rising edge after reset is released.
- R3: Each segment output equals the common line when the segment is dark and equals its inverse when the segment is lit. So with the common line high, a lit segment reads low.
- R4: Each full digit uses seven bits, bit 0 = segment a up to bit 6 = segment g. Codes 0..9 light the standard patterns, in hex with lit = 1: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Digit 0 occupies the low seven bits of the full-digit bus, with units on the low nibble of the input bus.
- R5: A full-digit code of 10 to 15 leaves all seven segments of that digit dark.
- R6: The half digit has two bits, bit 0 = segment b and bit 1 = segment c. Both are lit when the leading code is 1 and both are dark for any other leading code.
- R7: While overrange is set, both half-digit segments are lit and every full-digit segment is dark, whatever the digit codes are.
- R8: The sign output is lit exactly when the negative flag is set, with or without overrange.
- R9: Outputs reflect the inputs sampled on the previous rising edge, through one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_bcd_i | input | 4 | Leading half-digit code |
| full_bcd_i | input | 12 | Three full BCD digits, units in bits 3:0 |
| neg_i | input | 1 | Reading is negative |
| ovf_i | input | 1 | Reading is over range |
| full_seg_o | output | 21 | Segment drive, seven bits per full digit |
| half_seg_o | output | 2 | Half-digit segment drive (b, c) |
| sign_seg_o | output | 1 | Minus segment drive |
| com_o | output | 1 | Square-wave common anode drive |

## Verification
On every cycle, the assertions check several rules against the previous edge's inputs. The divider's common line may flip only at the end of a half period. Overrange darkens all full digits and lights the half digit. The sign segment follows the negative flag. Invalid digit codes stay dark. Only the bench's reference model can show the rest: the exact decoded pattern for each code, when the first toggle lands after reset, and the reset values. The bench gets these by sweeping every code through every digit position and by running a long pseudo-random stretch across several common-line periods.

// File: rtl/disp35_pkg.sv
package disp35_pkg;

    localparam int SEG_W = 7;

    typedef logic [SEG_W-1:0] seg7_t;

    // lit = 1 form, bit 0 = segment a
    function automatic seg7_t bcd_lit(input logic [3:0] code);
        seg7_t s;
        case (code)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;   // R5: invalid codes stay dark
        endcase
        return s;
    endfunction

endpackage

// File: rtl/disp35_div.sv
module disp35_div #(
    parameter int DIV_HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic com_q,
    output logic com_nx
);
    localparam int CW = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          com;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.com = ~st_q.com;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign com_q  = st_q.com;
    assign com_nx = rst_n ? st_d.com : 1'b0;

    // R2: the common line flips only after a full half period
    p_com_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.com != $past(st_q.com)) |-> ($past(st_q.cnt) == LAST));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

endmodule

// File: rtl/disp35_dec7.sv
module disp35_dec7
    import disp35_pkg::*;
(
    input  logic [3:0] code,
    input  logic       blank,
    output seg7_t      lit
);
    always_comb begin
        lit = blank ? '0 : bcd_lit(code);
    end
endmodule

// File: rtl/disp35_phase.sv
module disp35_phase #(
    parameter int W = 7
) (
    input  logic [W-1:0] lit,
    input  logic         com,
    output logic [W-1:0] drv
);
    // dark pins follow the common line, lit pins oppose it (R3)
    always_comb begin
        drv = lit ^ {W{com}};
    end
endmodule

// File: rtl/disp35_ca_drv.sv
module disp35_ca_drv
    import disp35_pkg::*;
#(
    parameter int DIV_HALF = 8,
    parameter int NUM_FULL = 3,
    parameter int BCD_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BCD_W-1:0]            lead_bcd_i,
    input  logic [NUM_FULL*BCD_W-1:0]   full_bcd_i,
    input  logic                        neg_i,
    input  logic                        ovf_i,
    output logic [NUM_FULL*SEG_W-1:0]   full_seg_o,
    output logic [1:0]                  half_seg_o,
    output logic                        sign_seg_o,
    output logic                        com_o
);
    localparam int FW = NUM_FULL * SEG_W;

    typedef struct packed {
        logic [FW-1:0] full;
        logic [1:0]    half;
        logic          sign;
    } drv_t;

    drv_t st_d, st_q;

    logic          com_q, com_nx;
    logic [FW-1:0] full_drv;
    logic [1:0]    half_lit, half_drv;
    logic [0:0]    sign_drv;

    disp35_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .com_q  (com_q),
        .com_nx (com_nx)
    );

    for (genvar g = 0; g < NUM_FULL; g++) begin : g_dig
        seg7_t lit;

        disp35_dec7 u_dec (
            .code  (full_bcd_i[g*BCD_W +: 4]),
            .blank (ovf_i),
            .lit   (lit)
        );

        disp35_phase #(.W(SEG_W)) u_ph (
            .lit (lit),
            .com (com_nx),
            .drv (full_drv[g*SEG_W +: SEG_W])
        );

        // R5: out-of-range code on a digit leaves it dark
        p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovf_i && (full_bcd_i[g*BCD_W +: 4] > 4'd9))
            |=> (full_seg_o[g*SEG_W +: SEG_W] == {SEG_W{com_o}}));
    end

    always_comb begin
        half_lit = {2{ovf_i || (lead_bcd_i == BCD_W'(1))}};
    end

    disp35_phase #(.W(2)) u_half_ph (
        .lit (half_lit),
        .com (com_nx),
        .drv (half_drv)
    );

    disp35_phase #(.W(1)) u_sign_ph (
        .lit (neg_i),
        .com (com_nx),
        .drv (sign_drv)
    );

    always_comb begin
        st_d      = st_q;
        st_d.full = full_drv;
        st_d.half = half_drv;
        st_d.sign = sign_drv[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_seg_o = st_q.full;
    assign half_seg_o = st_q.half;
    assign sign_seg_o = st_q.sign;
    assign com_o      = com_q;

    // R7: overrange darkens all full digits and lights the half digit
    p_ovf_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> (full_seg_o == {FW{com_o}}) && (half_seg_o == {2{~com_o}}));

    // R6: leading code 1 lights both half-digit segments
    p_half_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_bcd_i == BCD_W'(1)) |=> (half_seg_o == {2{~com_o}}));

    p_half_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_i && lead_bcd_i != BCD_W'(1)) |=> (half_seg_o == {2{com_o}}));

    // R8: sign segment follows the negative flag
    p_sign_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        neg_i |=> (sign_seg_o != com_o));

    p_sign_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !neg_i |=> (sign_seg_o == com_o));

endmodule

// File: tb/sim_disp35_ca_drv.sv
module sim_disp35_ca_drv;
    localparam int HALF = 8;
    localparam int NF   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lead_bcd = '0;
    logic [11:0] full_bcd = '0;
    logic        neg = 1'b0;
    logic        ovf = 1'b0;
    logic [20:0] full_seg;
    logic [1:0]  half_seg;
    logic        sign_seg;
    logic        com;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    disp35_ca_drv #(.DIV_HALF(HALF), .NUM_FULL(NF), .BCD_W(4)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .lead_bcd_i (lead_bcd),
        .full_bcd_i (full_bcd),
        .neg_i      (neg),
        .ovf_i      (ovf),
        .full_seg_o (full_seg),
        .half_seg_o (half_seg),
        .sign_seg_o (sign_seg),
        .com_o      (com)
    );

    always #10 clk = ~clk;

    // behavioural reference
    int pat [10] = '{'h3F, 'h06, 'h5B, 'h4F, 'h66, 'h6D, 'h7D, 'h07, 'h7F, 'h6F};
    int m_cnt = 0;
    int m_com = 0;
    int m_dig [NF];
    int m_code [NF];
    int m_half = 0;
    int m_sign = 0;
    int m_ovf = 0;
    int m_rst = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_com = 0; m_half = 0; m_sign = 0; m_ovf = 0; m_rst = 1;
            for (int i = 0; i < NF; i++) begin m_dig[i] = 0; m_code[i] = 0; end
        end else begin
            int inv7, lit;
            m_rst = 0;
            if (m_cnt == HALF - 1) begin m_cnt = 0; m_com = 1 - m_com; end
            else m_cnt = m_cnt + 1;
            inv7 = m_com ? 'h7F : 0;
            m_ovf = ovf;
            for (int i = 0; i < NF; i++) begin
                m_code[i] = int'(full_bcd[i*4 +: 4]);
                lit = (ovf || m_code[i] > 9) ? 0 : pat[m_code[i]];
                m_dig[i] = lit ^ inv7;
            end
            m_half = ((ovf || lead_bcd == 4'd1) ? 3 : 0) ^ (m_com ? 3 : 0);
            m_sign = (neg ? 1 : 0) ^ m_com;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            string t;
            // R3/R9: one register stage, phase against com
            chk(m_rst ? "R1" : "R2", int'(com), m_com);
            for (int i = 0; i < NF; i++) begin
                if (m_rst) t = "R1";
                else if (m_ovf != 0) t = "R7";
                else if (m_code[i] > 9) t = "R5";
                else t = "R4";
                chk(t, int'(full_seg[i*7 +: 7]), m_dig[i]);
            end
            chk(m_rst ? "R1" : "R6", int'(half_seg), m_half);
            chk(m_rst ? "R1" : "R8", int'(sign_seg), m_sign);
        end
    end

    task automatic drive(input int lead, input int f, input int n, input int o, input int cycles);
        @(negedge clk);
        #1;
        lead_bcd = 4'(lead);
        full_bcd = 12'(f);
        neg      = n[0];
        ovf      = o[0];
        repeat (cycles - 1) @(negedge clk);
    endtask

    initial begin
        // R1: reset held, inputs active but ignored
        lead_bcd = 4'd1; full_bcd = 12'h888; neg = 1'b1;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        lead_bcd = 4'd0; full_bcd = 12'h000; neg = 1'b0;
        repeat (2) @(negedge clk);
        // R4/R5/R6: sweep every code across all positions
        for (int v = 0; v < 16; v++) begin
            int f;
            f = (v & 15) | (((v + 3) & 15) << 4) | (((v + 7) & 15) << 8);
            drive(v % 3, f, v & 1, 0, 3);
        end
        // R7/R8: overrange with valid and invalid codes, both polarities
        drive(0, 'h123, 0, 1, 10);
        drive(1, 'h999, 1, 1, 10);
        drive(5, 'hFAF, 1, 1, 5);
        drive(1, 'h199, 1, 0, 6);
        // mixed pseudo-random stretch
        for (int k = 0; k < 300; k++) begin
            drive($urandom_range(0, 3), $urandom_range(0, 4095),
                  $urandom_range(0, 1), ($urandom_range(0, 7) == 0) ? 1 : 0, 1);
        end
        @(negedge clk);
        #1 done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        done = 1'b1;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule